// File: doc/BRIEF.md
# Four-Port Integer Calculator

The block serves four independent requesters, each on its own port, with unsigned 32-bit arithmetic. A requester starts a transaction by placing a nonzero command on its command lines together with the first operand. In the next cycle the command lines return to zero and the data lines carry the second operand. The block answers on the same port with a 2-bit status code and a 32-bit result.

Every port has its own capture logic, its own arithmetic unit and its own two-stage output pipeline. The answer therefore comes back a fixed three cycles after the second-operand cycle, regardless of what the other ports are doing. A requester keeps at most one request in flight on a port and waits for the answer before it issues the next one. The supported operations are add, subtract, shift left and shift right. An unknown command, a carry out of an add, or a subtract whose second operand exceeds its first each produce an error status with a zero result.

Top module: `calc_quad`

## Requirements
- R1: While rst_ni is low, every status output is 00 and every result output is zero. Command and data seen during reset start no request, so no status appears after reset is released.
- R2: A request's status appears on its port exactly three cycles after the second-operand cycle (four cycles after the command cycle). The status is 00 in the cycle before it and in the cycle after it.
- R3: Command 0001 (add) returns status 01 with op1+op2 when the unsigned sum fits in 32 bits. It returns status 10 when the sum carries out of bit 31.
- R4: Command 0010 (subtract) returns status 01 with op1-op2 when op2 <= op1, including a result of zero when they are equal. It returns status 10 when op2 > op1.
- R5: Command 0101 (shift left) and command 0110 (shift right, zero fill) shift op1 by op2[4:0] only, and always return status 01.
- R6: Any nonzero command other than 0001, 0010, 0101 and 0110 returns status 10.
- R7: The status is nonzero for exactly one cycle per request and is never 11. The result is zero whenever the status is not 01.
- R8: Requests on different ports may overlap in time and each returns its own correct answer on its own port.
- R9: A command value of 0000 while a port is idle starts no request, whatever the data lines carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 16 | Command of port p at bits [4p+3:4p] |
| data_i | input | 128 | Operand of port p at bits [32p+31:32p] |
| resp_o | output | 8 | Status of port p at bits [2p+1:2p]: 00 none, 01 success, 10 error |
| res_o | output | 128 | Result of port p at bits [32p+31:32p] |

## Verification
The hardest case to bring about is all four ports in flight at once, with their command, second-operand and answer cycles staggered so that one port's answer lands while another port is still capturing. The bench runs one stimulus thread per port in parallel, each with its own random idle gaps and a random mix of commands. Operands are steered toward the carry, borrow and shift-wrap edges, so the error paths also fire while other ports are busy. Directed cases cover exact equality on subtract, the all-ones add, shift amounts above 31 and a request that starts while reset is asserted.

// File: rtl/calc_pkg.sv
package calc_pkg;
  localparam int unsigned CMD_W  = 4;
  localparam int unsigned RESP_W = 2;

  typedef enum logic [CMD_W-1:0] {
    OP_NOP = 4'b0000,
    OP_ADD = 4'b0001,
    OP_SUB = 4'b0010,
    OP_SHL = 4'b0101,
    OP_SHR = 4'b0110
  } op_e;

  typedef enum logic [RESP_W-1:0] {
    RSP_NONE = 2'b00,
    RSP_OK   = 2'b01,
    RSP_ERR  = 2'b10
  } rsp_e;
endpackage

// File: rtl/calc_capture.sv
module calc_capture
  import calc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [DW-1:0]    data_i,
  output logic             vld_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [DW-1:0]    opa_o,
  output logic [DW-1:0]    opb_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      vld_o  <= 1'b0;
      cmd_o  <= '0;
      opa_o  <= '0;
      opb_o  <= '0;
    end else begin
      vld_o <= 1'b0;
      if (pend_q) begin
        // second cycle of the request: operand b
        opb_o  <= data_i;
        vld_o  <= 1'b1;
        pend_q <= 1'b0;
      end else if (cmd_i != '0) begin
        cmd_o  <= cmd_i;
        opa_o  <= data_i;
        pend_q <= 1'b1;
      end
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
endmodule

// File: rtl/calc_alu.sv
module calc_alu
  import calc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DW-1:0]     opa_i,
  input  logic [DW-1:0]     opb_i,
  output logic [RESP_W-1:0] resp_o,
  output logic [DW-1:0]     res_o
);
  localparam int unsigned SHW = $clog2(DW);

  logic [DW:0]    sum, dif;
  logic [SHW-1:0] sh;

  assign sum = {1'b0, opa_i} + {1'b0, opb_i};
  assign dif = {1'b0, opa_i} - {1'b0, opb_i};
  assign sh  = opb_i[SHW-1:0];

  always_comb begin
    resp_o = RSP_ERR;
    res_o  = '0;
    unique case (cmd_i)
      OP_ADD: if (!sum[DW]) begin resp_o = RSP_OK; res_o = sum[DW-1:0]; end
      OP_SUB: if (!dif[DW]) begin resp_o = RSP_OK; res_o = dif[DW-1:0]; end
      OP_SHL: begin resp_o = RSP_OK; res_o = opa_i << sh; end
      OP_SHR: begin resp_o = RSP_OK; res_o = opa_i >> sh; end
      default: ;
    endcase
  end
endmodule

// File: rtl/calc_pipe.sv
module calc_pipe
  import calc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [RESP_W-1:0] resp_i,
  input  logic [DW-1:0]     res_i,
  output logic [RESP_W-1:0] resp_o,
  output logic [DW-1:0]     res_o
);
  logic [RESP_W-1:0] resp_q;
  logic [DW-1:0]     res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_q <= RSP_NONE;
      res_q  <= '0;
      resp_o <= RSP_NONE;
      res_o  <= '0;
    end else begin
      resp_q <= vld_i ? resp_i : RSP_NONE;
      res_q  <= (vld_i && resp_i == RSP_OK) ? res_i : '0;
      resp_o <= resp_q;
      res_o  <= res_q;
    end
  end

  a_r7_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o != RSP_NONE |=> resp_o == RSP_NONE);
  a_r7_no_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o != 2'b11);
  a_r7_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o != RSP_OK |-> res_o == '0);
endmodule

// File: rtl/calc_quad.sv
module calc_quad
  import calc_pkg::*;
#(
  parameter int unsigned NP = 4,
  parameter int unsigned DW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NP*CMD_W-1:0]  cmd_i,
  input  logic [NP*DW-1:0]     data_i,
  output logic [NP*RESP_W-1:0] resp_o,
  output logic [NP*DW-1:0]     res_o
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    logic              vld;
    logic [CMD_W-1:0]  cmd;
    logic [DW-1:0]     opa, opb, res_c;
    logic [RESP_W-1:0] resp_c;

    calc_capture #(.DW(DW)) u_cap (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cmd_i (cmd_i[p*CMD_W +: CMD_W]),
      .data_i(data_i[p*DW +: DW]),
      .vld_o (vld),
      .cmd_o (cmd),
      .opa_o (opa),
      .opb_o (opb)
    );

    calc_alu #(.DW(DW)) u_alu (
      .cmd_i (cmd),
      .opa_i (opa),
      .opb_i (opb),
      .resp_o(resp_c),
      .res_o (res_c)
    );

    calc_pipe #(.DW(DW)) u_pipe (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (vld),
      .resp_i(resp_c),
      .res_i (res_c),
      .resp_o(resp_o[p*RESP_W +: RESP_W]),
      .res_o (res_o[p*DW +: DW])
    );

    a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld |-> ##2 resp_o[p*RESP_W +: RESP_W] != RSP_NONE);
    a_r3_add_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld && cmd == OP_ADD && opa > ~opb) |-> ##2 resp_o[p*RESP_W +: RESP_W] == RSP_ERR);
    a_r4_sub_borrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld && cmd == OP_SUB && opb > opa) |-> ##2 resp_o[p*RESP_W +: RESP_W] == RSP_ERR);
    a_r5_shift_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld && (cmd == OP_SHL || cmd == OP_SHR)) |-> ##2 resp_o[p*RESP_W +: RESP_W] == RSP_OK);
  end
endmodule

// File: tb/calc_quad_bench.sv
module calc_quad_bench;
  localparam int CLK_P = 10;
  localparam int NP = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic [3:0]  cmd_a [NP];
  logic [31:0] dat_a [NP];
  logic [4*NP-1:0]  cmd_bus;
  logic [DW*NP-1:0] data_bus;
  logic [2*NP-1:0]  resp_bus;
  logic [DW*NP-1:0] res_bus;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  for (genvar p = 0; p < NP; p++) begin : g_pack
    assign cmd_bus[p*4 +: 4]    = cmd_a[p];
    assign data_bus[p*DW +: DW] = dat_a[p];
  end

  calc_quad #(.NP(NP), .DW(DW)) u_calc_quad (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .cmd_i (cmd_bus),
    .data_i(data_bus),
    .resp_o(resp_bus),
    .res_o (res_bus)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                                output logic [1:0] r, output logic [31:0] d);
    logic [32:0] s;
    r = 2'b10; d = '0;
    case (c)
      4'b0001: begin s = {1'b0, a} + {1'b0, b};
               if (s <= 33'hFFFF_FFFF) begin r = 2'b01; d = s[31:0]; end end
      4'b0010: if (b <= a) begin r = 2'b01; d = a - b; end
      4'b0101: begin r = 2'b01; d = a << b[4:0]; end
      4'b0110: begin r = 2'b01; d = a >> b[4:0]; end
      default: ;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'b0001: return "R3";
      4'b0010: return "R4";
      4'b0101, 4'b0110: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_req(input int p, input logic [3:0] c, input logic [31:0] a,
                         input logic [31:0] b, input string extra);
    logic [1:0] er;
    logic [31:0] ed;
    string t;
    model(c, a, b, er, ed);
    t = {tag_of(c), extra};
    @(negedge clk); cmd_a[p] = c; dat_a[p] = a;
    @(negedge clk); cmd_a[p] = 4'h0; dat_a[p] = b;
    @(negedge clk); dat_a[p] = '0;
    @(negedge clk); check({"R2 pre ", t}, 64'(resp_bus[p*2 +: 2]), 64'd0);
    @(negedge clk);
    check({t, " resp"}, 64'(resp_bus[p*2 +: 2]), 64'(er));
    check({t, " R7 data"}, 64'(res_bus[p*DW +: DW]), 64'(ed));
    @(negedge clk); check({"R7 post ", t}, 64'(resp_bus[p*2 +: 2]), 64'd0);
  endtask

  task automatic rand_port(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      int sel;
      int v;
      logic [3:0] c;
      logic [31:0] a, b;
      sel = $urandom % 10;
      a = $urandom; b = $urandom;
      case (sel)
        0, 1: c = 4'b0001;
        2, 3: begin c = 4'b0010; if ($urandom % 2) b = a - ($urandom % 3) + 1; end
        4, 5: c = 4'b0101;
        6, 7: c = 4'b0110;
        8: begin v = $urandom % 11;
           c = (v < 2) ? 4'(3 + v) : (v == 2) ? 4'h7 : 4'(8 + v - 3); end
        default: begin c = 4'b0001; b = ~a + ($urandom % 3) - 1; end
      endcase
      repeat ($urandom % 4) @(negedge clk);
      run_req(p, c, a, b, " R8");
    end
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin cmd_a[p] = '0; dat_a[p] = '0; end
    void'($urandom(32'h5eed_0042));
    #1 rst_ni = 1'b0;
    // R1: reset state and no capture during reset
    @(negedge clk);
    check("R1 resp in reset", 64'(resp_bus), 64'd0);
    check("R1 data in reset", 64'(res_bus[63:0]), 64'd0);
    cmd_a[0] = 4'b0001; dat_a[0] = 32'd5;
    @(negedge clk); cmd_a[0] = 4'h0; dat_a[0] = 32'd6;
    @(negedge clk); dat_a[0] = '0; rst_ni = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); check("R1 no capture in reset", 64'(resp_bus[1:0]), 64'd0);
    end
    // R9: nop with busy data lines
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); dat_a[1] = $urandom;
      check("R9 nop", 64'(resp_bus[3:2]), 64'd0);
    end
    dat_a[1] = '0;
    // directed corners
    run_req(0, 4'b0001, 32'hFFFF_FFFF, 32'h1, " ovf");
    run_req(1, 4'b0001, 32'hFFFF_FFFE, 32'h1, " max");
    run_req(2, 4'b0010, 32'h1234_5678, 32'h1234_5678, " equal");
    run_req(3, 4'b0010, 32'h0, 32'h1, " borrow");
    run_req(0, 4'b0101, 32'h8000_0001, 32'd33, " amt33");
    run_req(1, 4'b0110, 32'h8000_0000, 32'd31, " amt31");
    run_req(2, 4'b0110, 32'hDEAD_BEEF, 32'hFFFF_FFE0, " amt0");
    run_req(3, 4'h3, 32'h1, 32'h1, " ill3");
    run_req(0, 4'h4, 32'h1, 32'h1, " ill4");
    run_req(1, 4'h7, 32'h1, 32'h1, " ill7");
    run_req(2, 4'hF, 32'h1, 32'h1, " illF");
    // R8: all ports in parallel
    fork
      rand_port(0, 60);
      rand_port(1, 60);
      rand_port(2, 60);
      rand_port(3, 60);
    join
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule